// File: doc/BRIEF.md
# Companded Test Tone Generator

This block produces 8-bit companded test samples for the send (tx) and receive (rx) paths of a voice echo canceller at the 8 kHz sample rate. Each path has its own 7-bit magnitude, already in logarithmic companded form. The generator only decides the sign of each sample, so the output is a rectified square-like wave of constant magnitude. Its sign follows one of two tone rates, an inverted copy of the first rate, or a pseudo-random bit.

Software programs a small register file through a write port. Every register write lands in a staging copy. Each sample strobe moves the staging copy into the active configuration and produces a new generated byte for each path. When a path's generator is disabled, that path passes its normal data straight through. A line selects A-law or µ-law coding, and its value is captured on each strobe.

Top module: `cmp_tone_gen`

## Requirements
- R1: The generated byte is formed as {sign, magnitude}. In A-law coding (law_sel=0) it is then XORed with 0x55. In µ-law coding (law_sel=1) it is XORed with 0x7F. law_sel is sampled on the strobe that produces the byte.
- R2: Pattern code 00 takes the sign from a 16-bit phase accumulator. The accumulator is cleared by reset and gains round(2105·65536/8000) = 17244 on every strobe. The sign is the accumulator's top bit after the increment.
- R3: An enabled path's output byte holds its value between strobes, whatever happens to law_sel or the pass-through input.
- R4: The magnitude field of an enabled path's byte, once the coding mask is removed, always equals the programmed 7-bit magnitude, for every value 0 to 127.
- R5: Pattern code 11 takes the sign from a 15-bit LFSR with polynomial x^15+x^14+1. The LFSR is seeded with 1 and shifts left by one place per strobe: new bit = q[14]^q[13], and that new bit enters at q[0] and is the sign. The LFSR is never zero.
- R6: After reset, the control register is 0 (both paths pass through, pattern 00), the tx magnitude is 0x00 and the rx magnitude is 0x55.
- R7: Register map: address 0 is control, with bits [1:0] the pattern code, bit 2 the tx enable and bit 3 the rx enable; address 1 is the tx magnitude [6:0]; address 2 is the rx magnitude [6:0]. A write to address 3 is ignored. A write changes the outputs only at the next strobe.
- R8: A disabled path drives its output combinationally from its pass-through input.
- R9: Pattern code 01 gives the inverse of the sign that pattern 00 gives at the same strobe.
- R10: Pattern code 10 uses a second 16-bit accumulator that gains round(2010·65536/8000) = 16466 per strobe. The sign is its top bit after the increment.
- R11: Both accumulators and the LFSR advance on every strobe whatever pattern is selected, so switching patterns continues the running sequence.
- R12: Both paths use the same sign on every strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Register write data |
| smp_stb | input | 1 | One-cycle 8 kHz sample strobe |
| law_sel | input | 1 | 0 = A-law, 1 = µ-law |
| tx_in | input | 8 | Send path pass-through data |
| rx_in | input | 8 | Receive path pass-through data |
| tx_out | output | 8 | Send path output byte |
| rx_out | output | 8 | Receive path output byte |

## Verification
The assertions check on every cycle that the active configuration, the accumulators and the LFSR move only on a strobe. They also check that the LFSR never reaches zero, that an enabled path's byte holds between strobes, and that its decoded magnitude matches the active magnitude. Only the bench scenarios can show that the sign sequences follow the correct tone increments and the correct LFSR polynomial, that the inverted pattern mirrors the base tone, and that the running sequences continue across a pattern switch. The bench scenarios also cover the reset defaults, the ignored address, and pass-through for every magnitude and both codings.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
   localparam int CODE_W    = 8;
   localparam int MAG_W     = 7;
   localparam int NUM_PATHS = 2;
   localparam int NUM_TONES = 2;
   localparam int PATH_TX   = 0;
   localparam int PATH_RX   = 1;

   typedef enum logic [1:0] {
      PAT_TONE_A     = 2'b00,
      PAT_TONE_A_INV = 2'b01,
      PAT_TONE_B     = 2'b10,
      PAT_NOISE      = 2'b11
   } pat_mode_e;

   typedef struct packed {
      logic      rx_en;
      logic      tx_en;
      pat_mode_e mode;
   } ctl_t;

   localparam logic [CODE_W-1:0] ALAW_MASK  = 8'h55;
   localparam logic [CODE_W-1:0] MULAW_MASK = 8'h7F;

   function automatic logic [CODE_W-1:0] compand_line(input logic sign,
                                                      input logic [MAG_W-1:0] mag,
                                                      input logic mu);
      logic [CODE_W-1:0] raw;
      raw = {sign, mag};
      return mu ? (raw ^ MULAW_MASK) : (raw ^ ALAW_MASK);
   endfunction

   function automatic logic [MAG_W-1:0] line_mag(input logic [CODE_W-1:0] code,
                                                 input logic mu);
      return mu ? (code[MAG_W-1:0] ^ MULAW_MASK[MAG_W-1:0])
                : (code[MAG_W-1:0] ^ ALAW_MASK[MAG_W-1:0]);
   endfunction
endpackage

// File: rtl/ctg_regs.sv
module ctg_regs
   import ctg_pkg::*;
#(
   parameter int               ADDR_W     = 2,
   parameter logic [MAG_W-1:0] TX_MAG_RST = 7'h00,
   parameter logic [MAG_W-1:0] RX_MAG_RST = 7'h55
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [CODE_W-1:0]                 wr_data,
   input  logic                              smp_stb,
   output ctl_t                              stg_ctl,
   output logic [NUM_PATHS-1:0][MAG_W-1:0]   stg_mag,
   output ctl_t                              act_ctl,
   output logic [NUM_PATHS-1:0][MAG_W-1:0]   act_mag
);
   localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(0);
   localparam logic [NUM_PATHS-1:0][MAG_W-1:0] MAG_RST = {RX_MAG_RST, TX_MAG_RST};

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ctg_regs: ADDR_W must be at least 2");
   end

   logic unused_wr_msb;
   assign unused_wr_msb = wr_data[CODE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_ctl <= '0;
         act_ctl <= '0;
      end else begin
         if (wr_en && (wr_addr == ADDR_CTL))
            stg_ctl <= ctl_t'(wr_data[$bits(ctl_t)-1:0]);
         if (smp_stb)
            act_ctl <= stg_ctl;
      end
   end

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_mag
      localparam logic [ADDR_W-1:0] ADDR_MAG = ADDR_W'(p + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_mag[p] <= MAG_RST[p];
            act_mag[p] <= MAG_RST[p];
         end else begin
            if (wr_en && (wr_addr == ADDR_MAG))
               stg_mag[p] <= wr_data[MAG_W-1:0];
            if (smp_stb)
               act_mag[p] <= stg_mag[p];
         end
      end
   end

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> ($stable(act_ctl) && $stable(act_mag))); // R7
endmodule

// File: rtl/ctg_phase_acc.sv
module ctg_phase_acc #(
   parameter int ACC_W   = 16,
   parameter int FS_HZ   = 8000,
   parameter int FREQ_HZ = 2105
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic msb_nxt
);
   localparam logic [63:0] INC64 =
      ((64'(FREQ_HZ) << ACC_W) + 64'(FS_HZ / 2)) / 64'(FS_HZ);
   localparam logic [ACC_W-1:0] INC = INC64[ACC_W-1:0];

   if (ACC_W < 8 || ACC_W > 32) begin : g_bad_w
      $error("ctg_phase_acc: ACC_W out of range");
   end
   if (FREQ_HZ <= 0 || 2 * FREQ_HZ >= FS_HZ) begin : g_bad_f
      $error("ctg_phase_acc: tone must lie below half the sample rate");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_nxt;

   assign acc_nxt = acc + INC;
   assign msb_nxt = acc_nxt[ACC_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (step) acc <= acc_nxt;
   end

   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(acc)); // R11
endmodule

// File: rtl/ctg_lfsr.sv
module ctg_lfsr #(
   parameter int          W    = 15,
   parameter int unsigned SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic bit_nxt
);
   function automatic logic [63:0] tap_mask(input int w);
      case (w)
         7:       return 64'h0000_0000_0000_0060;
         15:      return 64'h0000_0000_0000_6000;
         16:      return 64'h0000_0000_0000_D008;
         31:      return 64'h0000_0000_4800_0000;
         default: return 64'h0;
      endcase
   endfunction

   localparam logic [63:0]  TAP_ALL = tap_mask(W);
   localparam logic [W-1:0] TAPS    = TAP_ALL[W-1:0];
   localparam logic [W-1:0] SEED_W  = W'(SEED);

   if (TAP_ALL == 64'h0) begin : g_bad_w
      $error("ctg_lfsr: unsupported register length");
   end
   if (SEED_W == '0) begin : g_bad_seed
      $error("ctg_lfsr: seed must be nonzero");
   end

   logic [W-1:0] q;

   assign bit_nxt = ^(q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= SEED_W;
      else if (step) q <= {q[W-2:0], bit_nxt};
   end

   AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0); // R5
   AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(q)); // R11
endmodule

// File: rtl/ctg_path_enc.sv
module ctg_path_enc
   import ctg_pkg::*;
#(
   parameter logic [MAG_W-1:0] MAG_RST = 7'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic              sign_nxt,
   input  logic [MAG_W-1:0]  mag_nxt,
   input  logic [MAG_W-1:0]  mag_act,
   input  logic              law_sel,
   input  logic              en,
   input  logic [CODE_W-1:0] din,
   output logic [CODE_W-1:0] dout
);
   logic             sign_q;
   logic [MAG_W-1:0] mag_q;
   logic             mu_q;
   logic [CODE_W-1:0] gen_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_q <= 1'b0;
         mag_q  <= MAG_RST;
         mu_q   <= 1'b0;
      end else if (smp_stb) begin
         sign_q <= sign_nxt;
         mag_q  <= mag_nxt;
         mu_q   <= law_sel;
      end
   end

   assign gen_byte = compand_line(sign_q, mag_q, mu_q);
   assign dout     = en ? gen_byte : din;

   AST_MAG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (line_mag(dout, mu_q) == mag_act)); // R4
   AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !smp_stb) |=> $stable(dout)); // R3
endmodule

// File: rtl/cmp_tone_gen.sv
module cmp_tone_gen
   import ctg_pkg::*;
#(
   parameter int               ADDR_W     = 2,
   parameter int               ACC_W      = 16,
   parameter int               FS_HZ      = 8000,
   parameter int               TONE_A_HZ  = 2105,
   parameter int               TONE_B_HZ  = 2010,
   parameter int               LFSR_W     = 15,
   parameter int unsigned      LFSR_SEED  = 1,
   parameter logic [MAG_W-1:0] TX_MAG_RST = 7'h00,
   parameter logic [MAG_W-1:0] RX_MAG_RST = 7'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              smp_stb,
   input  logic              law_sel,
   input  logic [7:0]        tx_in,
   input  logic [7:0]        rx_in,
   output logic [7:0]        tx_out,
   output logic [7:0]        rx_out
);
   localparam int TONE_SEL_A = 0;
   localparam int TONE_SEL_B = 1;

   if (CODE_W != MAG_W + 1) begin : g_bad_code
      $error("cmp_tone_gen: code width must be magnitude width plus sign");
   end
   if (TONE_A_HZ == TONE_B_HZ) begin : g_same_tone
      $error("cmp_tone_gen: tone rates must differ");
   end

   ctl_t                            stg_ctl;
   ctl_t                            act_ctl;
   logic [NUM_PATHS-1:0][MAG_W-1:0] stg_mag;
   logic [NUM_PATHS-1:0][MAG_W-1:0] act_mag;
   logic [NUM_TONES-1:0]            tone_msb;
   logic                            noise_bit;
   logic                            sign_nxt;
   logic [NUM_PATHS-1:0]            path_en;
   logic [NUM_PATHS-1:0][CODE_W-1:0] path_in;
   logic [NUM_PATHS-1:0][CODE_W-1:0] path_out;

   ctg_regs #(
      .ADDR_W     (ADDR_W),
      .TX_MAG_RST (TX_MAG_RST),
      .RX_MAG_RST (RX_MAG_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .smp_stb (smp_stb),
      .stg_ctl (stg_ctl),
      .stg_mag (stg_mag),
      .act_ctl (act_ctl),
      .act_mag (act_mag)
   );

   for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
      localparam int FREQ = (t == TONE_SEL_A) ? TONE_A_HZ : TONE_B_HZ;
      ctg_phase_acc #(
         .ACC_W   (ACC_W),
         .FS_HZ   (FS_HZ),
         .FREQ_HZ (FREQ)
      ) u_acc (
         .clk     (clk),
         .rst_n   (rst_n),
         .step    (smp_stb),
         .msb_nxt (tone_msb[t])
      );
   end

   ctg_lfsr #(
      .W    (LFSR_W),
      .SEED (LFSR_SEED)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (smp_stb),
      .bit_nxt (noise_bit)
   );

   always_comb begin
      unique case (stg_ctl.mode)
         PAT_TONE_A:     sign_nxt = tone_msb[TONE_SEL_A];
         PAT_TONE_A_INV: sign_nxt = ~tone_msb[TONE_SEL_A];
         PAT_TONE_B:     sign_nxt = tone_msb[TONE_SEL_B];
         default:        sign_nxt = noise_bit;
      endcase
   end

   assign path_en[PATH_TX] = act_ctl.tx_en;
   assign path_en[PATH_RX] = act_ctl.rx_en;
   assign path_in[PATH_TX] = tx_in;
   assign path_in[PATH_RX] = rx_in;

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      localparam logic [MAG_W-1:0] MRST = (p == PATH_TX) ? TX_MAG_RST : RX_MAG_RST;
      ctg_path_enc #(
         .MAG_RST (MRST)
      ) u_enc (
         .clk      (clk),
         .rst_n    (rst_n),
         .smp_stb  (smp_stb),
         .sign_nxt (sign_nxt),
         .mag_nxt  (stg_mag[p]),
         .mag_act  (act_mag[p]),
         .law_sel  (law_sel),
         .en       (path_en[p]),
         .din      (path_in[p]),
         .dout     (path_out[p])
      );
   end

   assign tx_out = path_out[PATH_TX];
   assign rx_out = path_out[PATH_RX];

   AST_PASS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      !act_ctl.tx_en |-> (tx_out == tx_in)); // R8
endmodule

// File: tb/cmp_tone_gen_bench.sv
`timescale 1ns/1ps
module cmp_tone_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       smp_stb = 1'b0;
   logic       law_sel = 1'b0;
   logic [7:0] tx_in = 8'h3C;
   logic [7:0] rx_in = 8'hC3;
   logic [7:0] tx_out;
   logic [7:0] rx_out;

   always #2.5 clk = ~clk;

   cmp_tone_gen u_cmp_tone_gen (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .smp_stb (smp_stb), .law_sel (law_sel),
      .tx_in (tx_in), .rx_in (rx_in), .tx_out (tx_out), .rx_out (rx_out)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   localparam int unsigned INC_A = (2105 * 65536 + 4000) / 8000;
   localparam int unsigned INC_B = (2010 * 65536 + 4000) / 8000;

   // bench model
   int unsigned n_stb = 0;
   logic [14:0] lf = 15'h0001;
   logic [3:0]  stg_c = 4'h0, act_c = 4'h0;
   logic [6:0]  stg_tm = 7'h00, stg_rm = 7'h55;
   logic [6:0]  act_tm = 7'h00, act_rm = 7'h55;
   logic        law_m = 1'b0;
   logic        sgn_m = 1'b0;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] enc(input logic s, input logic [6:0] m, input logic mu);
      return {s, m} ^ (mu ? 8'h7F : 8'h55);
   endfunction

   function automatic logic [7:0] exp_tx();
      return act_c[2] ? enc(sgn_m, act_tm, law_m) : tx_in;
   endfunction
   function automatic logic [7:0] exp_rx();
      return act_c[3] ? enc(sgn_m, act_rm, law_m) : rx_in;
   endfunction

   task automatic chk_both(input string req);
      chk(req, tx_out, exp_tx());
      chk(req, rx_out, exp_rx());
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         2'd0: stg_c  = d[3:0];
         2'd1: stg_tm = d[6:0];
         2'd2: stg_rm = d[6:0];
         default: ;
      endcase
   endtask

   task automatic stb();
      int unsigned pa, pb;
      logic nb;
      @(negedge clk);
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      n_stb++;
      nb = lf[14] ^ lf[13];
      lf = {lf[13:0], nb};
      act_c = stg_c; act_tm = stg_tm; act_rm = stg_rm;
      law_m = law_sel;
      pa = n_stb * INC_A;
      pb = n_stb * INC_B;
      case (act_c[1:0])
         2'b00: sgn_m = pa[15];
         2'b01: sgn_m = ~pa[15];
         2'b10: sgn_m = pb[15];
         default: sgn_m = nb;
      endcase
   endtask

   initial begin
      #(5ns * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 / R8: reset state passes both paths through
      chk_both("R6");
      tx_in = 8'hA7; rx_in = 8'h19;
      @(negedge clk);
      chk_both("R8");

      // R6: reset rx magnitude 0x55 appears once rx enabled
      wr(2'd0, 8'h08);
      stb();
      chk_both("R6");

      // R7: writes not visible before strobe
      wr(2'd1, 8'h12);
      wr(2'd0, 8'h0C);
      chk_both("R7");
      stb();
      chk_both("R7");

      // R3: hold between strobes despite law and input changes
      for (int k = 0; k < 4; k++) begin
         law_sel = ~law_sel;
         tx_in = tx_in + 8'd37;
         @(negedge clk);
         chk_both("R3");
      end

      // R1 R2 R5 R9 R10 R11 R12: pattern and coding sweep
      for (int m = 0; m < 4; m++) begin
         for (int l = 0; l < 2; l++) begin
            wr(2'd0, {4'h0, 2'b11, 2'(m)});
            law_sel = l[0];
            for (int k = 0; k < 150; k++) begin
               stb();
               case (m)
                  0: chk_both("R2");
                  1: chk_both("R9");
                  2: chk_both("R10");
                  default: chk_both("R5");
               endcase
               chk("R12", tx_out[7] ^ (l[0] ? 1'b0 : 1'b0), rx_out[7]);
               if (k == 0) chk_both("R11");
               if (k == 1) chk_both("R1");
            end
         end
      end

      // R4: every magnitude in both codings
      wr(2'd0, 8'h0C);
      for (int v = 0; v < 128; v++) begin
         wr(2'd1, 8'(v));
         wr(2'd2, 8'(127 - v));
         law_sel = v[0];
         stb();
         chk_both("R4");
      end

      // R7: address 3 has no effect
      wr(2'd3, 8'hFF);
      stb();
      chk_both("R7");
      stb();
      chk_both("R7");

      // R8: tx disabled passes through while rx keeps generating
      wr(2'd0, 8'h0A);
      stb();
      chk_both("R8");
      for (int k = 0; k < 4; k++) begin
         tx_in = 8'(8'h11 * (k + 3));
         @(negedge clk);
         chk("R8", tx_out, tx_in);
         chk("R3", rx_out, exp_rx());
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule